// File: doc/BRIEF.md
# Strobe-Edge Watchdog Timer

This block watches a processor's activity strobe and reports when the processor has stopped kicking it. The strobe arrives asynchronously. It passes through a flop synchronizer, and only a high-to-low transition of the synchronized level counts as a kick. Each kick restarts a timeout counter from zero. If the counter reaches its limit with no kick, the active-low watchdog output goes low for a fixed number of cycles. The output then returns high and a fresh timeout period begins.

Timing is armed only while the system reset input is inactive. While reset is asserted, the counter is held at zero and the output is held high. Once reset is released, the first timeout starts. All pins are plain control and status signals, so no valid/ready handshake or back-pressure applies. The timeout length (`TIMEOUT_CYCLES`) and the pulse width (`PULSE_CYCLES`) are parameters counted in clock cycles. A real-time period such as one second is reached by choosing the timeout to match the clock rate.

Top module: `strobe_watchdog`

## Requirements
- R1: While `sys_rst_ni` is low, `wdog_no` is high, and it goes high at once when reset is asserted, even during a pulse. The timeout counter is held at zero during reset.
- R2: With no kick after reset is released, `wdog_no` first goes low exactly `TIMEOUT_CYCLES` rising clock edges after the release.
- R3: A high-to-low change on `strobe_i` passes through a two-flop synchronizer and an edge detector. It clears the counter on the third rising edge after the change. With no further kick, `wdog_no` goes low `TIMEOUT_CYCLES + 3` edges after the change.
- R4: A rising edge on `strobe_i`, a static high level, a static low level, or a low level held across reset release never restarts the timeout.
- R5: On expiry, `wdog_no` stays low for exactly `PULSE_CYCLES` cycles.
- R6: After the pulse, `wdog_no` returns high and a full new timeout period of `TIMEOUT_CYCLES` edges starts at the edge that ends the pulse.
- R7: Strobe falling edges that reach the timer while `wdog_no` is low are ignored. They do not lengthen the pulse or shorten the following timeout.
- R8: A kick that reaches the timer on the same edge the timeout would expire takes priority, so counter clears spaced `TIMEOUT_CYCLES` edges apart never produce a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| sys_rst_ni | input | 1 | System reset status, active low, asynchronous assert; holds the timer cleared |
| strobe_i | input | 1 | Asynchronous activity strobe; a falling edge is a kick |
| wdog_no | output | 1 | Watchdog status, active low; low for `PULSE_CYCLES` after a timeout |

## Verification
The main function is exercised with streams of kicks spaced at several intervals. Intervals well below the limit, exactly at the limit, and just past it tell a correct priority between a kick and expiry apart from an off-by-one counter or a timer that ignores kicks. Falling edges injected during a pulse, rising-only activity, and a strobe held low across reset release separate true edge detection from level sensing and from a pulse that can be extended. Resets applied mid-count and mid-pulse, with the pulse measured against the next expiry, show whether the timer restarts cleanly and times the full period after each pulse.

// File: rtl/swd_pkg.sv
package swd_pkg;

  typedef enum logic {
    SWD_ARMED = 1'b0,
    SWD_PULSE = 1'b1
  } swd_state_e;

  function automatic int unsigned swd_max(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/swd_strobe_sync.sv
module swd_strobe_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic kick_o
);

  localparam int unsigned TOP = SYNC_STAGES;

  // chain[0..TOP-1] synchronize, chain[TOP] holds the previous settled level
  logic [TOP:0] chain_q;

  // Free-running so the chain is settled by the time reset is released
  always_ff @(posedge clk_i) begin
    chain_q <= {chain_q[TOP-1:0], strobe_i};
  end

  assign kick_o = chain_q[TOP] & ~chain_q[TOP-1];

  // R4: a kick is a single-cycle event, never a level
  a_r4_kick_is_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_o |=> !kick_o);

endmodule

// File: rtl/swd_timer.sv
module swd_timer
  import swd_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 1000,
  parameter int unsigned PULSE_CYCLES   = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic wdog_no
);

  localparam int unsigned SPAN  = swd_max(swd_max(TIMEOUT_CYCLES, PULSE_CYCLES), 2);
  localparam int unsigned CNT_W = $clog2(SPAN);
  localparam logic [CNT_W-1:0] T_LAST = CNT_W'(TIMEOUT_CYCLES - 1);
  localparam logic [CNT_W-1:0] P_LAST = CNT_W'(PULSE_CYCLES - 1);

  swd_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_limit;

  assign at_limit = (state_q == SWD_ARMED) ? (cnt_q == T_LAST) : (cnt_q == P_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    unique case (state_q)
      SWD_ARMED: begin
        if (kick_i) begin
          cnt_d = '0;                 // kick wins over expiry
        end else if (at_limit) begin
          state_d = SWD_PULSE;
          cnt_d   = '0;
        end
      end
      SWD_PULSE: begin
        if (at_limit) begin           // kicks ignored here
          state_d = SWD_ARMED;
          cnt_d   = '0;
        end
      end
      default: begin
        state_d = SWD_ARMED;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SWD_ARMED;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign wdog_no = (state_q != SWD_PULSE);

  // R1: output high whenever reset is asserted
  a_r1_reset_high: assert property (@(posedge clk_i)
    !rst_ni |-> (wdog_no && cnt_q == '0));

  // R2: the output only falls after a full, unkicked period
  a_r2_expiry_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdog_no) |-> ($past(cnt_q) == T_LAST && !$past(kick_i)));

  // R3: a kick while armed restarts counting from zero
  a_r3_kick_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_no && kick_i) |=> (wdog_no && cnt_q == '0));

  // R5: pulse counter never passes the pulse length
  a_r5_pulse_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdog_no |-> (cnt_q <= P_LAST));

  // R6: after the pulse a fresh period begins
  a_r6_rearm_fresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdog_no) |-> (cnt_q == '0 && $past(cnt_q) == P_LAST));

  // R7: a kick during the pulse does not end it early
  a_r7_pulse_ignores_kick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wdog_no && kick_i && cnt_q != P_LAST) |=> !wdog_no);

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int unsigned TIMEOUT_CYCLES = 1000,
  parameter int unsigned PULSE_CYCLES   = 100,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic sys_rst_ni,
  input  logic strobe_i,
  output logic wdog_no
);

  logic kick;

  swd_strobe_sync #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (sys_rst_ni),
    .strobe_i (strobe_i),
    .kick_o   (kick)
  );

  swd_timer #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .PULSE_CYCLES   (PULSE_CYCLES)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (sys_rst_ni),
    .kick_i  (kick),
    .wdog_no (wdog_no)
  );

endmodule

// File: tb/strobe_watchdog_tb.sv
`timescale 1ns/1ps
module strobe_watchdog_tb;

  localparam int T = 20;
  localparam int P = 8;
  localparam int NV = 9;
  // {watch cycles, expect expiry}
  localparam logic [8:0] VEC [NV] = '{
    {8'd10, 1'b0}, {8'd16, 1'b0}, {8'd17, 1'b0}, {8'd10, 1'b0},
    {8'd31, 1'b1}, {8'd12, 1'b0}, {8'd35, 1'b1}, {8'd16, 1'b0},
    {8'd40, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b1;
  logic wdog_n;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  strobe_watchdog #(
    .TIMEOUT_CYCLES (T),
    .PULSE_CYCLES   (P),
    .SYNC_STAGES    (2)
  ) u_dut (
    .clk_i      (clk),
    .sys_rst_ni (rst_n),
    .strobe_i   (strobe),
    .wdog_no    (wdog_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input int n, input logic lvl);
    rst_n  = 1'b0;
    strobe = lvl;
    repeat (n) step();
    rst_n = 1'b1;
  endtask

  task automatic watch(input int w, output int first, output int lows);
    first = 0;
    lows  = 0;
    for (int c = 1; c <= w; c++) begin
      step();
      if (!wdog_n) begin
        lows++;
        if (first == 0) first = c;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int first, lows, bad, second;
    logic prev;
    @(negedge clk);

    // Table of kick intervals
    do_reset(5, 1'b1);
    for (int v = 0; v < NV; v++) begin
      strobe = 1'b1;
      repeat (3) step();
      strobe = 1'b0;
      watch(int'(VEC[v][8:1]), first, lows);
      chk(first == (VEC[v][0] ? T + 3 : 0), $sformatf("R3/R8 vec%0d first-low", v),
          first, VEC[v][0] ? T + 3 : 0);
      chk(lows == (VEC[v][0] ? P : 0), $sformatf("R5 vec%0d low-width", v),
          lows, VEC[v][0] ? P : 0);
    end

    // R4: static low strobe after one fall gives repeated expiries
    strobe = 1'b1;
    repeat (3) step();
    strobe = 1'b0;
    first = 0; second = 0; prev = 1'b1;
    for (int c = 1; c <= 2 * T + P + 6; c++) begin
      step();
      if (prev && !wdog_n) begin
        if (first == 0) first = c;
        else if (second == 0) second = c;
      end
      prev = wdog_n;
    end
    chk(first == T + 3, "R3 static-low first expiry", first, T + 3);
    chk(second == 2 * T + P + 3, "R4 static-low no re-kick", second, 2 * T + P + 3);

    // R1: reset state held longer than the timeout
    rst_n = 1'b0;
    strobe = 1'b1;
    bad = 0;
    for (int c = 0; c < 2 * T; c++) begin
      step();
      if (!wdog_n) bad++;
    end
    chk(bad == 0, "R1 high during reset", bad, 0);

    // R2, R5, R6, R7: release, pulse with ignored kick, full next period
    rst_n = 1'b1;
    bad = 0; first = 0;
    for (int c = 1; c <= 2 * T + 2 * P + 2; c++) begin
      bit exp_low;
      step();
      exp_low = (c >= T && c < T + P) || (c >= 2 * T + P && c < 2 * T + 2 * P);
      if (!wdog_n && first == 0) first = c;
      if (wdog_n == exp_low) bad++;
      if (c == T + 1) strobe = 1'b0;
      if (c == T + 4) strobe = 1'b1;
    end
    chk(first == T, "R2 expiry after release", first, T);
    chk(bad == 0, "R5/R6/R7 pulse pattern mismatches", bad, 0);

    // R1/R2: reset mid-count, then mid-pulse
    do_reset(5, 1'b1);
    repeat (15) step();
    rst_n = 1'b0;
    step();
    chk(wdog_n == 1'b1, "R1 reset mid-count", wdog_n, 1);
    step();
    rst_n = 1'b1;
    watch(T + 2, first, lows);
    chk(first == T, "R2 full period after mid-count reset", first, T);
    chk(wdog_n == 1'b0, "R5 in pulse before reset", wdog_n, 0);
    rst_n = 1'b0;
    #1;
    chk(wdog_n == 1'b1, "R1 reset ends pulse at once", wdog_n, 1);
    step();

    // R4: low level across release, then rising edge only
    do_reset(5, 1'b0);
    first = 0;
    for (int c = 1; c <= T + 2; c++) begin
      step();
      if (!wdog_n && first == 0) first = c;
      if (c == 5) strobe = 1'b1;
    end
    chk(first == T, "R4 low level and rising edge do not kick", first, T);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule